// File: doc/BRIEF.md
# Slotted Ring Station Controller

This block is one node of a synchronous, one-way packet ring. It also arbitrates the local bus of a station that holds several processing modules. On every clock it takes the packet from the upstream node's latch into its own latch, so one packet moves one hop per cycle. A node never buffers more than that one packet, and it never discards a packet that still has work to do.

The controller works out during the upstream cycle whether the arriving packet belongs to its station. If it does, the packet is put on the station bus in the next cycle, ahead of any local module, and is also passed on down the ring. The target module answers on a Received line by the end of that bus cycle. The next node down the ring then turns the forwarded packet into an acknowledge or a negative acknowledge. It removes the packet instead when it was an accepted read, because the later data reply serves as the answer. Each module has two request lines: one for transfers inside the station and one for injecting a packet into a free ring slot.

Top module: `ring_station_ctrl`

## Requirements
- R1: While `rst` is high, the registered outputs settle at the next clock edge to an empty ring slot (bit 92 clear), `ring_out_dlv` low and `bus_vld` low.
- R2: Packet layout: bit 92 is valid, bits 91:90 are the kind (00 read, 01 write, 10 response/acknowledge, 11 negative acknowledge), 89:77 the destination id, 76:64 the source id and 63:0 the body. An id is ring(4), station(4) and module(5), from MSB down. A valid `ring_in` packet that was not delivered upstream appears unchanged on `ring_out` one cycle later.
- R3: A packet is for this station when the top 8 bits of its destination id (after the rewrite of R7/R8) equal `MY_ID`. The cycle after it enters the latch, `bus_vld`, `bus_from_ring` and `ring_out_dlv` are high and `bus_pkt` equals `ring_out`.
- R4: In a cycle where an arriving packet is for this station, neither `on_gnt` nor `off_gnt` is asserted.
- R5: `off_gnt` is asserted only when the slot arriving after the rewrite is empty. In that cycle the granted module's packet enters `ring_out` on the next cycle. When the slot is free and some `off_req` is high, one off-station grant is given.
- R6: `on_gnt` is asserted only when no arriving packet is for this station and no off-station grant is given. When those hold and some `on_req` is high, one on-station grant is given. The granted packet appears on `bus_pkt` the next cycle with `bus_from_ring` low.
- R7: A delivered request (`ring_in_dlv` high) that is not accepted (`ring_in_rcvd` low) becomes a negative acknowledge. An accepted write becomes a response. In both cases the destination and source ids are swapped and the body is kept.
- R8: The slot is emptied when the delivered packet was an accepted read, or when it was a response or negative acknowledge.
- R9: Within each request class, a module granted in two cycles in a row was the only requester of that class in the second cycle.
- R10: At most one of all `on_gnt` and `off_gnt` bits is high in any cycle.
- R11: In a closed ring of controllers, every read or write issued by a module gets exactly one completion, and no packet is lost. A completion is a Received answer on the station bus, a response, or a negative acknowledge.
- R12: `ring_out_rcvd` follows `bus_rcvd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in | input | 93 | Upstream node's latch |
| ring_in_dlv | input | 1 | Upstream put `ring_in` on its station bus |
| ring_in_rcvd | input | 1 | Upstream bus Received line |
| ring_out | output | 93 | This node's latch |
| ring_out_dlv | output | 1 | `ring_out` is being delivered on this station bus |
| ring_out_rcvd | output | 1 | This station's Received line, passed downstream |
| on_req | input | N_MOD | Per-module on-station request |
| off_req | input | N_MOD | Per-module off-station request |
| mod_pkt | input | N_MOD*93 | Per-module outgoing packet, module i at bits i*93 upward |
| on_gnt | output | N_MOD | On-station grant; packet taken at the clock edge |
| off_gnt | output | N_MOD | Off-station grant; packet taken at the clock edge |
| bus_vld | output | 1 | Station bus carries a packet for a module |
| bus_from_ring | output | 1 | Bus packet came from the ring |
| bus_pkt | output | 93 | Packet on the station bus |
| bus_rcvd | input | 1 | Received line driven by the bus target |

## Verification
Two things collide in one cycle. A ring packet bound for the station can arrive just as local modules want the bus. At the same time, the node downstream must rewrite a delivered packet in the very slot a module there wants to fill. The bench builds four controllers into a closed ring and opens with every module requesting at once, then runs seeded random traffic with random refusals. In every cycle it checks the grants against the computed arrival and slot state, and it checks that every request ends with exactly one completion.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int RING_W   = 4;
  localparam int STN_W    = 4;
  localparam int MOD_W    = 5;
  localparam int DATA_W   = 64;
  localparam int ID_W     = RING_W + STN_W + MOD_W;
  localparam int STN_ID_W = RING_W + STN_W;

  typedef enum logic [1:0] {
    K_RD  = 2'b00,
    K_WR  = 2'b01,
    K_RSP = 2'b10,
    K_NAK = 2'b11
  } kind_e;

  typedef struct packed {
    logic              vld;
    kind_e             kind;
    logic [ID_W-1:0]   dst;
    logic [ID_W-1:0]   src;
    logic [DATA_W-1:0] body;
  } pkt_t;

  localparam int PKT_W = $bits(pkt_t);
endpackage

// File: rtl/rsc_rr_arb.sv
module rsc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, pick;
  logic          won;
  logic [N-1:0]  prev_gnt_q;

  always_comb begin
    gnt  = '0;
    pick = last_q;
    won  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (en && req[idx] && !won) begin
        won      = 1'b1;
        pick     = IW'(idx);
        gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q     <= IW'(N - 1);
      prev_gnt_q <= '0;
    end else begin
      prev_gnt_q <= gnt;
      if (won) last_q <= pick;
    end
  end

  // R9: a repeat winner had no competitor
  p_rr_fair_r9: assert property (@(posedge clk) disable iff (rst)
    (|(prev_gnt_q & gnt)) |-> ($countones(req) == 1));
endmodule

// File: rtl/rsc_slot_rewrite.sv
module rsc_slot_rewrite
  import rsc_pkg::*;
(
  input  pkt_t                up,
  input  logic                up_dlv,
  input  logic                up_rcvd,
  input  logic [STN_ID_W-1:0] my_id,
  output pkt_t                nx,
  output logic                for_me
);
  always_comb begin
    nx = up;
    if (up.vld && up_dlv) begin
      if (up.kind == K_RSP || up.kind == K_NAK) begin
        nx = '0;
      end else if (up_rcvd && up.kind == K_RD) begin
        nx = '0;
      end else begin
        nx.kind = up_rcvd ? K_RSP : K_NAK;
        nx.dst  = up.src;
        nx.src  = up.dst;
      end
    end
  end

  assign for_me = nx.vld && (nx.dst[ID_W-1 -: STN_ID_W] == my_id);
endmodule

// File: rtl/ring_station_ctrl.sv
module ring_station_ctrl
  import rsc_pkg::*;
#(
  parameter int                  N_MOD = 4,
  parameter logic [STN_ID_W-1:0] MY_ID = 'h10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PKT_W-1:0]       ring_in,
  input  logic                   ring_in_dlv,
  input  logic                   ring_in_rcvd,
  output logic [PKT_W-1:0]       ring_out,
  output logic                   ring_out_dlv,
  output logic                   ring_out_rcvd,
  input  logic [N_MOD-1:0]       on_req,
  input  logic [N_MOD-1:0]       off_req,
  input  logic [N_MOD*PKT_W-1:0] mod_pkt,
  output logic [N_MOD-1:0]       on_gnt,
  output logic [N_MOD-1:0]       off_gnt,
  output logic                   bus_vld,
  output logic                   bus_from_ring,
  output logic [PKT_W-1:0]       bus_pkt,
  input  logic                   bus_rcvd
);
  pkt_t             up_p, nx_p, lat_q, bus_q;
  logic             hit, dlv_q, bvld_q, bfr_q;
  logic [PKT_W-1:0] on_v, off_v;
  logic [PKT_W-1:0] mod_arr [N_MOD];

  for (genvar i = 0; i < N_MOD; i++) begin : g_unpack
    assign mod_arr[i] = mod_pkt[i*PKT_W +: PKT_W];
  end

  assign up_p = pkt_t'(ring_in);

  rsc_slot_rewrite u_rw (
    .up     (up_p),
    .up_dlv (ring_in_dlv),
    .up_rcvd(ring_in_rcvd),
    .my_id  (MY_ID),
    .nx     (nx_p),
    .for_me (hit)
  );

  rsc_rr_arb #(.N(N_MOD)) u_off_arb (
    .clk(clk), .rst(rst), .en(!nx_p.vld), .req(off_req), .gnt(off_gnt)
  );

  rsc_rr_arb #(.N(N_MOD)) u_on_arb (
    .clk(clk), .rst(rst), .en(!hit && !(|off_gnt)), .req(on_req), .gnt(on_gnt)
  );

  always_comb begin
    on_v  = '0;
    off_v = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (on_gnt[i])  on_v  = on_v  | mod_arr[i];
      if (off_gnt[i]) off_v = off_v | mod_arr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      dlv_q  <= 1'b0;
      bvld_q <= 1'b0;
      bfr_q  <= 1'b0;
      bus_q  <= '0;
    end else begin
      if (nx_p.vld)      lat_q <= nx_p;
      else if (|off_gnt) lat_q <= pkt_t'(off_v);
      else               lat_q <= '0;
      dlv_q  <= hit;
      bvld_q <= hit || (|on_gnt);
      bfr_q  <= hit;
      if (hit)          bus_q <= nx_p;
      else if (|on_gnt) bus_q <= pkt_t'(on_v);
      else              bus_q <= '0;
    end
  end

  assign ring_out      = lat_q;
  assign ring_out_dlv  = dlv_q;
  assign ring_out_rcvd = bus_rcvd;
  assign bus_vld       = bvld_q;
  assign bus_from_ring = bfr_q;
  assign bus_pkt       = bus_q;

  // R1: reset empties slot and bus
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!ring_out[PKT_W-1] && !bus_vld && !ring_out_dlv));

  // R10: single bus owner
  p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({on_gnt, off_gnt}));

  // R5: no injection over a passing packet
  p_off_free_r5: assert property (@(posedge clk) disable iff (rst)
    (|off_gnt) |-> !(ring_in[PKT_W-1] && !ring_in_dlv));

  // R4: ring delivery had the bus to itself
  p_ring_first_r4: assert property (@(posedge clk) disable iff (rst)
    bus_from_ring |-> $past(on_gnt == '0 && off_gnt == '0));

  // R7: refused request returns as negative acknowledge
  p_nack_r7: assert property (@(posedge clk) disable iff (rst)
    (ring_in[PKT_W-1] && ring_in_dlv && !ring_in_rcvd && !ring_in[PKT_W-2])
      |=> (ring_out[PKT_W-1] && ring_out[PKT_W-2 -: 2] == 2'b11));
endmodule

// File: tb/tb_ring_station_ctrl.sv
module tb_ring_station_ctrl;
  import rsc_pkg::*;
  localparam int NS = 4, NM = 3, NG = NS * NM, PW = PKT_W, IDW = ID_W;
  localparam int MAXREQ = 300, LIMIT = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0][PW-1:0]    r_out, bp;
  logic [NS-1:0]            dlv, rcv_o, bv, bfr, brc;
  logic [NS-1:0][NM-1:0]    onr, offr, ong, offg;
  logic [NS-1:0][NM*PW-1:0] mpk;

  always #2 clk = ~clk;

  for (genvar s = 0; s < NS; s++) begin : g_st
    localparam int UP = (s + NS - 1) % NS;
    ring_station_ctrl #(.N_MOD(NM), .MY_ID(8'(16 + s))) dut (
      .clk(clk), .rst(rst),
      .ring_in(r_out[UP]), .ring_in_dlv(dlv[UP]), .ring_in_rcvd(rcv_o[UP]),
      .ring_out(r_out[s]), .ring_out_dlv(dlv[s]), .ring_out_rcvd(rcv_o[s]),
      .on_req(onr[s]), .off_req(offr[s]), .mod_pkt(mpk[s]),
      .on_gnt(ong[s]), .off_gnt(offg[s]),
      .bus_vld(bv[s]), .bus_from_ring(bfr[s]), .bus_pkt(bp[s]), .bus_rcvd(brc[s]));
  end

  int nchk = 0, nfail = 0, issued = 0, done = 0, cyc = 0;
  bit out_busy[NG], rep_pend[NG], tx_act[NG], tx_rep[NG], tx_off[NG];
  logic [PW-1:0] tx_pkt[NG], rep_pkt[NG];
  logic [PW-1:0] e_lat[NS], e_bp[NS];
  bit e_dlv[NS], e_bv[NS];
  logic [NM-1:0] lg_on[NS], lg_off[NS];
  bit have_exp = 0;

  function automatic logic [PW-1:0] mk(bit v, logic [1:0] k, logic [IDW-1:0] d,
                                        logic [IDW-1:0] sr, logic [63:0] b);
    return {v, k, d, sr, b};
  endfunction
  function automatic logic [1:0] f_kind(logic [PW-1:0] p); return p[PW-2 -: 2]; endfunction
  function automatic logic [IDW-1:0] f_dst(logic [PW-1:0] p); return p[PW-4 -: IDW]; endfunction
  function automatic logic [IDW-1:0] f_src(logic [PW-1:0] p); return p[PW-4-IDW -: IDW]; endfunction
  function automatic int gidx(logic [IDW-1:0] id);
    return int'(id[MOD_W +: STN_W]) * NM + int'(id[MOD_W-1:0]);
  endfunction
  // R7 R8: expected content after the downstream rewrite
  function automatic logic [PW-1:0] ref_fwd(logic [PW-1:0] p, bit d, bit rc);
    if (!p[PW-1] || !d) return p;
    if (f_kind(p) >= 2'b10) return '0;
    if (rc && f_kind(p) == 2'b00) return '0;
    return mk(1'b1, rc ? 2'b10 : 2'b11, f_src(p), f_dst(p), p[63:0]);
  endfunction
  function automatic bit ref_mine(logic [PW-1:0] p, int s);
    return p[PW-1] && (f_dst(p)[IDW-1 -: 8] == 8'(16 + s));
  endfunction

  task automatic chk(bit ok, string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic complete(int g);
    chk(out_busy[g], "R11 extra completion", PW'(out_busy[g]), PW'(1));
    out_busy[g] = 0;
    done++;
  endtask

  initial begin
    bit idle;
    void'($urandom(32'd2024));
    onr = '0; offr = '0; mpk = '0; brc = '0;
    for (int g = 0; g < NG; g++) begin
      out_busy[g] = 0; rep_pend[g] = 0; tx_act[g] = 0; tx_rep[g] = 0; tx_off[g] = 0;
    end
    for (int s = 0; s < NS; s++) begin lg_on[s] = '0; lg_off[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      chk(!r_out[s][PW-1] && !dlv[s] && !bv[s], "R1 reset state",
          PW'({r_out[s][PW-1], dlv[s], bv[s]}), '0);
    end
    rst = 1'b0;
    while (cyc < LIMIT) begin
      // check registers loaded at the last edge
      if (have_exp) begin
        for (int s = 0; s < NS; s++) begin
          chk(r_out[s] == e_lat[s], "R2 R7 R8 R5 ring latch", r_out[s], e_lat[s]);
          chk(dlv[s] == e_dlv[s] && bfr[s] == e_dlv[s], "R3 deliver flags",
              PW'({dlv[s], bfr[s]}), PW'({e_dlv[s], e_dlv[s]}));
          chk(bv[s] == e_bv[s], "R3 R6 bus valid", PW'(bv[s]), PW'(e_bv[s]));
          if (e_bv[s]) chk(bp[s] == e_bp[s], "R3 R6 bus packet", bp[s], e_bp[s]);
        end
      end
      // bus targets answer
      for (int s = 0; s < NS; s++) begin
        brc[s] = 1'b0;
        if (bv[s]) begin
          logic [PW-1:0] p;
          int tg;
          bit acc;
          p  = bp[s];
          tg = s * NM + int'(f_dst(p)[MOD_W-1:0]);
          if (f_kind(p) <= 2'b01) begin
            acc = !rep_pend[tg] && !(tx_act[tg] && tx_rep[tg]) && ($urandom % 4 != 0);
            brc[s] = acc;
            if (acc && f_kind(p) == 2'b00) begin
              rep_pend[tg] = 1;
              rep_pkt[tg]  = mk(1'b1, 2'b10, f_src(p), f_dst(p), ~p[63:0]);
            end
            if (!bfr[s] && !(acc && f_kind(p) == 2'b00)) complete(gidx(f_src(p)));
          end else begin
            brc[s] = 1'b1;
            complete(tg);
          end
        end
      end
      // modules prepare traffic; cycle 0 is a directed all-request burst
      for (int g = 0; g < NG; g++) begin
        int s, m;
        s = g / NM; m = g % NM;
        if (!tx_act[g]) begin
          if (rep_pend[g]) begin
            tx_pkt[g] = rep_pkt[g]; tx_rep[g] = 1; rep_pend[g] = 0; tx_act[g] = 1;
            tx_off[g] = (int'(f_dst(rep_pkt[g])[MOD_W +: STN_W]) != s);
          end else if (!out_busy[g] && issued < MAXREQ && (cyc == 0 || $urandom % 5 == 0)) begin
            int ts, tm;
            ts = $urandom % NS; tm = $urandom % NM;
            if (ts == s && tm == m) tm = (tm + 1) % NM;
            tx_pkt[g] = mk(1'b1, ($urandom % 2 == 1) ? 2'b01 : 2'b00,
                           {4'd1, 4'(ts), 5'(tm)}, {4'd1, 4'(s), 5'(m)},
                           {$urandom, $urandom});
            tx_off[g] = (ts != s); tx_rep[g] = 0; tx_act[g] = 1; out_busy[g] = 1;
            issued++;
          end
        end
        onr[s][m] = tx_act[g] && !tx_off[g];
        offr[s][m] = tx_act[g] && tx_off[g];
        mpk[s][m*PW +: PW] = tx_pkt[g];
      end
      #1;
      // judge grants and compute next-edge expectations
      for (int s = 0; s < NS; s++) begin
        int up;
        logic [PW-1:0] nx, onp, offp;
        bit hit;
        up  = (s + NS - 1) % NS;
        nx  = ref_fwd(r_out[up], dlv[up], brc[up]);
        hit = ref_mine(nx, s);
        onp = '0; offp = '0;
        chk($countones({ong[s], offg[s]}) <= 1, "R10 grants",
            PW'({ong[s], offg[s]}), '0);
        chk(rcv_o[s] == brc[s], "R12 received pass", PW'(rcv_o[s]), PW'(brc[s]));
        if (hit) chk(ong[s] == '0 && offg[s] == '0, "R4 ring first",
                     PW'({ong[s], offg[s]}), '0);
        if (nx[PW-1]) chk(offg[s] == '0, "R5 slot busy", PW'(offg[s]), '0);
        else if (|offr[s]) chk(|offg[s], "R5 free slot used", PW'(offg[s]), PW'(offr[s]));
        if (|offg[s]) chk(ong[s] == '0, "R6 blocked by injection", PW'(ong[s]), '0);
        else if (!hit && |onr[s]) chk(|ong[s], "R6 on grant", PW'(ong[s]), PW'(onr[s]));
        chk((ong[s] & ~onr[s]) == '0 && (offg[s] & ~offr[s]) == '0, "R10 grant w/o req",
            PW'({ong[s], offg[s]}), PW'({onr[s], offr[s]}));
        if ((lg_on[s] & ong[s]) != '0)
          chk($countones(onr[s]) == 1, "R9 on rotation", PW'(onr[s]), PW'(ong[s]));
        if ((lg_off[s] & offg[s]) != '0)
          chk($countones(offr[s]) == 1, "R9 off rotation", PW'(offr[s]), PW'(offg[s]));
        lg_on[s] = ong[s]; lg_off[s] = offg[s];
        for (int m = 0; m < NM; m++) begin
          if (ong[s][m])  begin onp  = tx_pkt[s*NM+m]; tx_act[s*NM+m] = 0; end
          if (offg[s][m]) begin offp = tx_pkt[s*NM+m]; tx_act[s*NM+m] = 0; end
        end
        e_lat[s] = nx[PW-1] ? nx : offp;
        e_dlv[s] = hit;
        e_bv[s]  = hit || (|ong[s]);
        e_bp[s]  = hit ? nx : onp;
      end
      have_exp = 1;
      @(negedge clk);
      cyc++;
      idle = (issued >= MAXREQ);
      for (int g = 0; g < NG; g++)
        if (out_busy[g] || tx_act[g] || rep_pend[g]) idle = 0;
      if (idle) break;
    end
    if (cyc >= LIMIT) begin
      nfail++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", done, issued);
    end
    chk(issued == done && issued == MAXREQ, "R11 all completed", PW'(done), PW'(issued));
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule